// File: doc/BRIEF.md
# Dual-Enable Asynchronous SRAM Core

This block is a synthesizable stand-in for a byte-wide static memory of 8192 words that keeps an asynchronous-style control interface. A fast internal clock samples the control pins once per cycle. The pins are two chip selects of opposite polarity, a low-true write strobe, a low-true output gate, a 13-bit address and a data port. The data port is split into an input bus, an output bus and an output-enable flag, so a pad wrapper can build the tri-state driver.

A write is open for as long as both selects are asserted and the write strobe is low. It is committed to the array on the first sampled cycle in which that condition stops holding. The address and data stored are the ones sampled on the last cycle in which the condition still held. Any of the three controls can close the write.

The output enable and the power-down flag are registered, so they change one clock after the pins that cause the change. The read data follows a new address in that same one-cycle step, and a location written on a given edge is read back with its new value.

Top module: `dual_en_sram`

## Requirements
- R1: Every one of the 8192 byte locations, at addresses 0x0000 through 0x1FFF, returns the last byte committed to it when it is read.
- R2: If `sel_lo_n` is 1 or `sel_hi` is 0 on a sampled edge, `dout_en` is 0 after that edge, whatever `wen_n` and `oen_n` are.
- R3: While the part is selected and `wen_n` is 0, `dout_en` is 0 after each edge, even when `oen_n` is 0.
- R4: When the part is selected, `wen_n` is 1 and `oen_n` is 0 on an edge, `dout_en` is 1 after that edge and `dout` holds the byte stored at the sampled address.
- R5: When the part is selected with `wen_n` and `oen_n` both 1, `dout_en` is 0 after the edge.
- R6: A write is committed on the first edge at which the write condition is false after being true. Any of three changes ends it: `wen_n` rising, `sel_lo_n` rising or `sel_hi` falling. The address and data stored are the ones sampled on the last edge at which the condition held.
- R7: If the address changes while a write stays open, only the address held on the write's last active edge is changed. Addresses visited earlier in that write keep their old contents.
- R8: If a select drops on the same edge at which `wen_n` rises, `dout_en` stays 0 after that edge, even with `oen_n` at 0.
- R9: `pwr_dn` is 1 after any edge at which either select is inactive, and 0 after an edge at which both are active.
- R10: In read mode `dout` reflects a new address one edge after the address is sampled. This includes an address whose write is committed on that same edge, which reads back the new byte.
- R11: While `rst` is high, `dout_en` is 0 and `pwr_dn` is 1 after each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Word address |
| sel_lo_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| wen_n | input | 1 | Write strobe, active low |
| oen_n | input | 1 | Output gate, active low |
| din | input | 8 | Data from the pad into the array |
| dout | output | 8 | Data from the array toward the pad |
| dout_en | output | 1 | Pad driver enable for `dout` |
| pwr_dn | output | 1 | Deselected / power-down indication |

## Verification
Writes are closed in three separate ways: by the strobe rising, by the low-true select rising and by the high-true select falling. Each way is read back, which shows whether every terminating edge commits the data. A write that moves its address while open separates committing the last sampled address from committing every address visited. Reads of the lowest and highest addresses and a sweep of sixteen locations check the address decode. A read issued on the same edge a write closes at that address checks that the read path forwards the new byte. The select and gate combinations are crossed with the strobe and the output gate, including a select dropping together with the strobe, to check the output enable and the power-down flag in each mode.

// File: rtl/dual_en_sram_pkg.sv
package dual_en_sram_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_QUIET = 2'd1,
    MODE_RD    = 2'd2,
    MODE_WR    = 2'd3
  } pin_mode_t;
endpackage

// File: rtl/dual_en_sram_decode.sv
module dual_en_sram_decode
  import dual_en_sram_pkg::*;
(
  input  logic      sel_lo_n,
  input  logic      sel_hi,
  input  logic      wen_n,
  input  logic      oen_n,
  output pin_mode_t mode,
  output logic      selected
);
  always_comb begin
    selected = !sel_lo_n && sel_hi;
    if (!selected)      mode = MODE_OFF;
    else if (!wen_n)    mode = MODE_WR;
    else if (!oen_n)    mode = MODE_RD;
    else                mode = MODE_QUIET;
  end
endmodule

// File: rtl/dual_en_sram_wtrack.sv
module dual_en_sram_wtrack #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_open,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (rst) open_q <= 1'b0;
    else     open_q <= wr_open;
  end

  // Hold the last address/data seen while the write was open.
  always_ff @(posedge clk) begin
    if (wr_open) begin
      commit_addr <= addr;
      commit_data <= din;
    end
  end

  // Terminating edge: open last sample, closed now.
  assign commit = open_q && !wr_open;
endmodule

// File: rtl/dual_en_sram_array.sv
module dual_en_sram_array #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [DW-1:0] fwd_q;
  logic          fwd_sel;

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_q <= mem[ra];
  end

  // Same-edge write forwarding keeps the RAM in read-first mode.
  always_ff @(posedge clk) begin
    fwd_sel <= we && (wa == ra);
    fwd_q   <= wd;
  end

  assign rd = fwd_sel ? fwd_q : rd_q;
endmodule

// File: rtl/dual_en_sram.sv
module dual_en_sram
  import dual_en_sram_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          sel_lo_n,
  input  logic          sel_hi,
  input  logic          wen_n,
  input  logic          oen_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          pwr_dn
);
  pin_mode_t     mode;
  logic          selected;
  logic          commit;
  logic [AW-1:0] commit_addr;
  logic [DW-1:0] commit_data;

  dual_en_sram_decode u_dec (
    .sel_lo_n (sel_lo_n),
    .sel_hi   (sel_hi),
    .wen_n    (wen_n),
    .oen_n    (oen_n),
    .mode     (mode),
    .selected (selected)
  );

  dual_en_sram_wtrack #(.AW(AW), .DW(DW)) u_wtrk (
    .clk         (clk),
    .rst         (rst),
    .wr_open     (mode == MODE_WR),
    .addr        (addr),
    .din         (din),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data)
  );

  dual_en_sram_array #(.AW(AW), .DW(DW)) u_arr (
    .clk (clk),
    .we  (commit),
    .wa  (commit_addr),
    .wd  (commit_data),
    .ra  (addr),
    .rd  (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_en <= 1'b0;
      pwr_dn  <= 1'b1;
    end else begin
      dout_en <= (mode == MODE_RD);
      pwr_dn  <= !selected;
    end
  end
endmodule

// File: rtl/dual_en_sram_chk.sv
module dual_en_sram_chk (
  input logic clk,
  input logic rst,
  input logic sel_lo_n,
  input logic sel_hi,
  input logic wen_n,
  input logic oen_n,
  input logic dout_en,
  input logic pwr_dn
);
  assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_lo_n || !sel_hi) |=> !dout_en);

  assert_write_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!sel_lo_n && sel_hi && !wen_n) |=> !dout_en);

  assert_read_drives_R4: assert property (@(posedge clk) disable iff (rst)
    (!sel_lo_n && sel_hi && wen_n && !oen_n) |=> dout_en);

  assert_gate_off_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!sel_lo_n && sel_hi && wen_n && oen_n) |=> !dout_en);

  assert_pwr_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (sel_lo_n || !sel_hi) |=> pwr_dn);

  assert_pwr_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (!sel_lo_n && sel_hi) |=> !pwr_dn);
endmodule

bind dual_en_sram dual_en_sram_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_lo_n (sel_lo_n),
  .sel_hi   (sel_hi),
  .wen_n    (wen_n),
  .oen_n    (oen_n),
  .dout_en  (dout_en),
  .pwr_dn   (pwr_dn)
);

// File: tb/dual_en_sram_tb.sv
module dual_en_sram_tb;
  localparam int AW = 13;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          sel_lo_n = 1'b1;
  logic          sel_hi = 1'b0;
  logic          wen_n = 1'b1;
  logic          oen_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic          pwr_dn;

  always #10 clk = ~clk;

  dual_en_sram #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
    .wen_n(wen_n), .oen_n(oen_n), .din(din), .dout(dout),
    .dout_en(dout_en), .pwr_dn(pwr_dn)
  );

  typedef struct {
    logic          exp_en;
    logic          exp_pd;
    logic          chk_data;
    logic [DW-1:0] exp_d;
    string         tag;
  } exp_t;

  exp_t          sb [$];
  logic [DW-1:0] model [int];
  logic          m_open = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  int            n_run = 0;
  int            n_bad = 0;
  bit            finished = 1'b0;

  // Driver: apply pins for one cycle and queue the expected outputs.
  task automatic step(input logic [AW-1:0] a, input logic cl, input logic ch,
                      input logic w, input logic o, input logic [DW-1:0] d,
                      input string tag);
    exp_t e;
    logic sel, wopen;
    @(negedge clk);
    addr = a; sel_lo_n = cl; sel_hi = ch; wen_n = w; oen_n = o; din = d;
    sel   = !cl && ch;
    wopen = sel && !w;
    if (m_open && !wopen) model[int'(m_addr)] = m_data;
    if (wopen) begin m_addr = a; m_data = d; end
    m_open   = wopen;
    e.exp_en = sel && w && !o;
    e.exp_pd = !sel;
    e.chk_data = e.exp_en && model.exists(int'(a));
    e.exp_d  = e.chk_data ? model[int'(a)] : '0;
    e.tag    = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    step(a, 1'b0, 1'b1, 1'b0, 1'b1, d, tag);
    step(a, 1'b0, 1'b1, 1'b1, 1'b1, d, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(a, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, tag);
  endtask

  // Monitor: compare outputs well after each rising edge.
  always @(posedge clk) begin
    #2;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (dout_en !== e.exp_en || pwr_dn !== e.exp_pd) begin
        n_bad++;
        $display("FAIL %s: dout_en/pwr_dn = %b/%b, expected %b/%b",
                 e.tag, dout_en, pwr_dn, e.exp_en, e.exp_pd);
      end
      if (e.chk_data) begin
        n_run++;
        if (dout !== e.exp_d) begin
          n_bad++;
          $display("FAIL %s: dout = %h, expected %h", e.tag, dout, e.exp_d);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_run++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    // R11: reset state with a read pattern on the pins
    sel_lo_n = 1'b0; sel_hi = 1'b1; oen_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    n_run++;
    if (dout_en !== 1'b0 || pwr_dn !== 1'b1) begin
      n_bad++;
      $display("FAIL R11: dout_en/pwr_dn = %b/%b, expected 0/1", dout_en, pwr_dn);
    end
    @(negedge clk);
    rst = 1'b0;

    // R6: terminated by write strobe rising; R1 lowest address
    wr(13'h0000, 8'hA5, "R6_wen_end");
    rd(13'h0000, "R1_low_addr");

    // R6: terminated by active-low select rising
    step(13'h1FFF, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, "R6_sel_lo_end");
    step(13'h1FFF, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R2_sel_lo_off");
    rd(13'h1FFF, "R1_high_addr");

    // R3: output gate low during write; R6: terminated by active-high select falling
    step(13'h0800, 1'b0, 1'b1, 1'b0, 1'b0, 8'h77, "R3_gate_ignored");
    step(13'h0800, 1'b0, 1'b1, 1'b0, 1'b0, 8'h77, "R3_gate_ignored");
    step(13'h0800, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R2_sel_hi_off");
    rd(13'h0800, "R6_sel_hi_end");

    // R7: address moves while write open
    wr(13'h0010, 8'h99, "R7_setup");
    step(13'h0010, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11, "R7_first_addr");
    step(13'h0020, 1'b0, 1'b1, 1'b0, 1'b1, 8'h22, "R7_last_addr");
    step(13'h0020, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R5_idle");
    rd(13'h0010, "R7_untouched");
    rd(13'h0020, "R7_committed");

    // R8: select drops on same edge as strobe rises, gate low
    step(13'h0030, 1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, "R8_open");
    step(13'h0030, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R8_simul_end");
    step(13'h0030, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R9_sel_hi_low");
    rd(13'h0030, "R8_data");

    // R2/R9: deselect crossed with strobe/gate
    for (int i = 0; i < 4; i++)
      step(13'h0000, 1'b1, 1'b0, i[0], i[1], 8'hFF, "R2_desel_cross");
    step(13'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R5_quiet");
    step(13'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R9_selected");

    // R10: back-to-back reads with changing address, and same-edge forwarding
    rd(13'h0000, "R10_walk");
    rd(13'h1FFF, "R10_walk");
    rd(13'h0020, "R10_walk");
    step(13'h0040, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3, "R10_fwd_open");
    step(13'h0040, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R10_fwd_read");

    // R1: sweep of spread addresses
    for (int i = 0; i < 16; i++)
      wr(AW'(i * 509 + 7), DW'(i * 37 + 1), "R1_sweep_wr");
    for (int i = 0; i < 16; i++)
      rd(AW'(i * 509 + 7), "R1_sweep_rd");

    @(negedge clk);
    sel_lo_n = 1'b1; sel_hi = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    summary();
  end
endmodule